// File: doc/BRIEF.md
# Interrupt Enable and In-Service Gate

This block holds an 8-bit control register with two defined bits. One bit is a master enable. The other is an in-service flag. The block sits between a single pending-request line and the processor core. From these it decides whether the core may take an interrupt now, and it reports that decision on one output.

Hardware sets the in-service flag when the handler acknowledges an interrupt. While the flag is set, no further interrupt is allowed. There are two ways to clear the flag:
- A return-from-interrupt strobe clears it automatically.
- Software clears it through the register port inside a service routine, which permits nesting.

The register port is a plain single-cycle read/write port with a byte address compare. Reads are combinational.

Top module: `irq_gate`

## Requirements
- R1: After reset is asserted, the register reads 8'h00 and `take_o` is 0.
- R2: `take_o` is 1 exactly when `req_i` is 1, the enable bit (bit 0) is 1 and the in-service bit (bit 1) is 0. It follows the registered bits combinationally.
- R3: When the enable bit is 0, `take_o` stays 0 whatever the state of `req_i`.
- R4: An `ack_i` pulse sets the in-service bit on the next clock edge.
- R5: While the in-service bit is 1, `take_o` stays 0.
- R6: A write with `wr_en_i` to address `ADDR` loads bits 1:0 from `wdata_i[1:0]`. A write to any other address changes nothing. A software clear of bit 1 re-enables delivery, which allows nesting.
- R7: A `reti_i` pulse clears the in-service bit on the next edge.
- R8: When `ack_i` and a write clearing bit 1 occur in the same cycle, bit 1 ends up set. `ack_i` also outranks `reti_i`.
- R9: Bits 7:2 always read 0, even after a write of ones. When the address does not match, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | An interrupt request is pending |
| ack_i | input | 1 | The handler has acknowledged an interrupt |
| reti_i | input | 1 | Return-from-interrupt or pop-interrupt executed |
| addr_i | input | AW | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the register at `addr_i` |
| take_o | output | 1 | The core may take an interrupt |

## Verification
If the enable bit is wrong, the error shows on `take_o` in the same cycle that `req_i` is high. It also shows on `rdata_o` at the next read. If the in-service bit is stuck, the error shows one edge after an `ack_i` or a `reti_i`, again through `take_o` and the readback. Comparing both outputs against a model every cycle catches a wrong priority or a wrong reserved bit within one cycle of the triggering stimulus.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned BIT_EN = 0;
  localparam int unsigned BIT_IS = 1;
  typedef struct packed {
    logic in_svc;
    logic en;
  } ctl_t;
endpackage

// File: rtl/irq_gate_reg.sv
module irq_gate_reg
  import irq_gate_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter logic [AW-1:0] ADDR = AW'(5)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             reti_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output ctl_t             ctl_o
);
  logic sel;
  ctl_t ctl_q, ctl_d;

  assign sel = wr_en_i && (addr_i == ADDR);

  always_comb begin
    ctl_d = ctl_q;
    if (sel) begin
      ctl_d.en     = wdata_i[BIT_EN];
      ctl_d.in_svc = wdata_i[BIT_IS];
    end
    if (reti_i) ctl_d.in_svc = 1'b0;
    // hardware set outranks software write and return
    if (ack_i)  ctl_d.in_svc = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/irq_gate_rd.sv
module irq_gate_rd
  import irq_gate_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter logic [AW-1:0] ADDR = AW'(5)
) (
  input  logic [AW-1:0]    addr_i,
  input  ctl_t             ctl_i,
  output logic [REG_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR) begin
      rdata_o[BIT_EN] = ctl_i.en;
      rdata_o[BIT_IS] = ctl_i.in_svc;
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter logic [AW-1:0] ADDR = AW'(5)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          ack_i,
  input  logic          reti_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          take_o
);
  ctl_t ctl;

  irq_gate_reg #(.AW(AW), .ADDR(ADDR)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .reti_i(reti_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .ctl_o(ctl)
  );

  irq_gate_rd #(.AW(AW), .ADDR(ADDR)) u_rd (
    .addr_i(addr_i), .ctl_i(ctl), .rdata_o(rdata_o)
  );

  assign take_o = req_i & ctl.en & ~ctl.in_svc;
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] ADDR = AW'(5)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          ack_i,
  input logic          reti_i,
  input logic [AW-1:0] addr_i,
  input logic          wr_en_i,
  input logic [7:0]    wdata_i,
  input logic [7:0]    rdata_o,
  input logic          take_o
);
  // R4
  ack_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (!take_o || !req_i));
  // R5
  insvc_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR && rdata_o[1]) |-> !take_o);
  // R3
  disabled_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR && !rdata_o[0]) |-> !take_o);
  // R9
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7:2] == 6'd0);
  // R2
  no_req_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !take_o);
  // R7
  reti_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ack_i && !(wr_en_i && addr_i == ADDR)) |=> (addr_i != ADDR || !rdata_o[1]));
endmodule

bind irq_gate irq_gate_chk #(.AW(AW), .ADDR(ADDR)) u_chk (.*);

// File: tb/irq_gate_tb.sv
module irq_gate_tb;
  localparam int AW = 8;
  localparam logic [AW-1:0] A = 8'd5;
  logic clk_i = 0, rst_ni = 0;
  logic req_i = 0, ack_i = 0, reti_i = 0, wr_en_i = 0;
  logic [AW-1:0] addr_i = A;
  logic [7:0] wdata_i = 0, rdata_o;
  logic take_o;
  int vecs = 0, errs = 0;
  bit m_en = 0, m_is = 0;

  always #2 clk_i = ~clk_i;

  irq_gate #(.AW(AW), .ADDR(A)) u_dut (.*);

  task automatic cmp(string r);
    logic [7:0] er;
    logic et;
    er = (addr_i == A) ? {6'd0, m_is, m_en} : 8'd0;
    et = req_i && m_en && !m_is;
    vecs++;
    if (rdata_o !== er || take_o !== et) begin
      errs++;
      $display("FAIL %s: rdata=%h take=%b expected rdata=%h take=%b", r, rdata_o, take_o, er, et);
    end
  endtask

  // drive inputs, check combinational view, then step model across the edge
  task automatic step(string r, bit rq, bit ak, bit rt, bit we, logic [7:0] wd, logic [7:0] ad = A);
    req_i = rq; ack_i = ak; reti_i = rt; wr_en_i = we; wdata_i = wd; addr_i = ad;
    #1 cmp(r);
    @(posedge clk_i);
    if (we && ad == A) begin m_en = wd[0]; m_is = wd[1]; end
    if (rt) m_is = 0;
    if (ak) m_is = 1;
    #1;
    ack_i = 0; reti_i = 0; wr_en_i = 0; addr_i = A;
    #0.5 cmp(r);
  endtask

  initial begin
    #1000;
    errs++;
    $display("FAIL watchdog: timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #5 cmp("R1");
    rst_ni = 1;
    @(posedge clk_i); #1;
    step("R3", 1, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 1, 8'hFE, 8'd3);  // R6 wrong address ignored
    step("R9", 1, 0, 0, 1, 8'hFC);        // R9 reserved ones
    step("R6", 0, 0, 0, 1, 8'h01);
    step("R2", 1, 0, 0, 0, 0);
    step("R4", 1, 1, 0, 0, 0);
    step("R5", 1, 0, 0, 0, 0);
    step("R6", 1, 0, 0, 1, 8'h01);        // nesting via sw clear
    step("R4", 1, 1, 0, 0, 0);
    step("R7", 1, 0, 1, 0, 0);
    step("R2", 1, 0, 0, 0, 0);
    step("R8", 1, 1, 0, 1, 8'h01);        // ack beats sw clear
    step("R5", 1, 0, 0, 0, 0);
    step("R8", 1, 1, 1, 0, 0);            // ack beats reti
    step("R9", 1, 0, 0, 0, 0, 8'd7);
    step("R7", 0, 0, 1, 0, 0);
    step("R6", 1, 0, 0, 1, 8'h02);        // sw set in-service
    step("R5", 1, 0, 0, 1, 8'h00);
    step("R3", 0, 0, 0, 0, 0);
    rst_ni = 0; #1 m_en = 0; m_is = 0; cmp("R1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule